// File: doc/BRIEF.md
# Low-Power Wake Controller

This block sequences a small processor core between normal execution and two power-saving states. A power-save request with a mode bit parks the core in a light state (Idle) or a deep state (Sleep). In Idle, only the core clock is stopped. The main clock source keeps running, and each peripheral keeps or loses its clock according to its own keep-running bit. In Sleep, the clock source, the core and every peripheral are stopped.

The block wakes when one of three events occurs: an enabled interrupt with a high enough priority, a watchdog time-out strobe, or a non-power-on reset. A wake from Idle restores the core clock on the next cycle. A wake from Sleep first restarts the oscillator and waits a programmable number of start-up cycles.

A one-cycle resume pulse marks the point where execution continues after the power-save instruction. Three sticky flags record the cause: Idle wake, Sleep wake and watchdog time-out. Software clears them by writing ones, and a power-on reset clears them all. The watchdog counter, interrupt vectoring and oscillator analog are outside this block and appear only as strobes and enables.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After power-on reset (rst_n low), the block is running: cpu_clk_en_o=1, osc_en_o=1, all periph_clk_en_o bits 1, resume_o=0, and all three status flags are 0.
- R2: A save_req_i with save_mode_i=0 while running moves the block to Idle on the next cycle. In Idle, cpu_clk_en_o=0, osc_en_o=1, and periph_clk_en_o equals periph_idle_run_i, where bit i at 1 keeps peripheral i clocked.
- R3: fs_clk_en_o equals cfd_en_i while running or in Idle, and is 0 in Sleep and during start-up.
- R4: Interrupt source i wakes the block only when irq_req_i[i]=1, irq_en_i[i]=1, and its 3-bit priority field irq_prio_i[3i+2:3i] is strictly greater than cpu_prio_i. A disabled source, or a source with equal or lower priority, leaves the low-power state unchanged.
- R5: A wake event (qualifying interrupt or wdt_to_i) in Idle during cycle t gives cpu_clk_en_o=1, resume_o=1 and sts_idle_o=1 at cycle t+1.
- R6: A save_req_i with save_mode_i=1 while running enters Sleep on the next cycle. In Sleep, cpu_clk_en_o, osc_en_o and all periph_clk_en_o bits are 0.
- R7: A wake event in Sleep during cycle t, with N = start_cnt_i sampled in that cycle, does the following. It sets osc_en_o and sts_sleep_o from cycle t+1. It keeps cpu_clk_en_o low until cycle t+1+max(N,1), when cpu_clk_en_o and resume_o rise together.
- R8: wdt_to_i in Idle sets sts_idle_o and sts_wdto_o. In Sleep it sets sts_sleep_o and sts_wdto_o. While running, it changes neither the state nor any flag.
- R9: resume_o is high for exactly one cycle per wake.
- R10: oth_rst_i in any state returns the block to running on the next cycle and sets sts_idle_o. It raises no resume pulse, and overrides a save_req_i in the same cycle.
- R11: The flags are sticky. sts_clr_i bit 0 clears Idle, bit 1 clears Sleep and bit 2 clears time-out. A set in the same cycle wins over a clear.
- R12: A save_req_i that arrives in Idle, Sleep or start-up is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| oth_rst_i | input | 1 | Non-power-on reset strobe |
| save_req_i | input | 1 | Power-save request strobe |
| save_mode_i | input | 1 | 0 = Idle, 1 = Sleep |
| irq_req_i | input | NUM_SRC | Interrupt requests |
| irq_en_i | input | NUM_SRC | Per-source interrupt enables |
| irq_prio_i | input | NUM_SRC*PRIO_W | Packed per-source priorities |
| cpu_prio_i | input | PRIO_W | Current core priority |
| wdt_to_i | input | 1 | Watchdog time-out strobe |
| start_cnt_i | input | START_W | Oscillator start-up cycles |
| periph_idle_run_i | input | NUM_PERIPH | Keep-running-in-Idle bits |
| cfd_en_i | input | 1 | Clock-failure detection enabled |
| sts_clr_i | input | 3 | Write-one-to-clear for the flags |
| cpu_clk_en_o | output | 1 | Core clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| periph_clk_en_o | output | NUM_PERIPH | Peripheral clock enables |
| fs_clk_en_o | output | 1 | Fail-safe RC clock enable |
| resume_o | output | 1 | One-cycle resume pulse |
| sts_idle_o | output | 1 | Idle wake / reset flag |
| sts_sleep_o | output | 1 | Sleep wake flag |
| sts_wdto_o | output | 1 | Watchdog time-out flag |

## Verification
Directed runs cover three interrupt cases: priority equal to the core level, a disabled source, and priority one step above the core level. Together they isolate the strict-greater and enable terms of the wake test. A Sleep wake with a start-up count of 16 measures the exact delay before the core clock returns. Separate strobes test that the watchdog affects state and flags only in a low-power state, and that a reset overrides a simultaneous request. A long random phase applies sparse requests, random priorities and modes, start-up counts that include 0 and 1, and occasional clears and resets. It compares every output against a cycle model on every cycle, which catches ordering faults between wake, clear and reset.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2,
    PM_WARM  = 2'd3
  } pm_state_e;

  localparam int STS_N     = 3;
  localparam int STS_IDLE  = 0;
  localparam int STS_SLEEP = 1;
  localparam int STS_WDTO  = 2;

  // A source outranks the core only when strictly above it.
  function automatic logic prio_wins(input logic [7:0] src, input logic [7:0] cur);
    return src > cur;
  endfunction

  // Cycles spent in start-up for a programmed count (zero behaves as one).
  function automatic int unsigned warm_span(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/lpm_irq_qual.sv
module lpm_irq_qual import lpm_pkg::*; #(
  parameter int NUM_SRC = 4,
  parameter int PRIO_W  = 3
) (
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         cur_i,
  output logic [NUM_SRC-1:0]        cand_o,
  output logic                      hit_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign cand_o[g] = req_i[g] & en_i[g] &
                       prio_wins(8'(prio_i[g*PRIO_W +: PRIO_W]), 8'(cur_i));
  end

  assign hit_o = |cand_o;

  always_comb begin
    if (hit_o) begin
      AST_HIT_NEEDS_EN: assert (|(req_i & en_i)); // R4
    end
  end

endmodule

// File: rtl/lpm_startup_timer.sv
module lpm_startup_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done_o = run_i && (cnt_q <= CNT_W'(1));

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/lpm_status.sv
module lpm_status import lpm_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_N-1:0] set_i,
  input  logic [STS_N-1:0] clr_i,
  output logic [STS_N-1:0] flags_o
);

  logic [STS_N-1:0] flag_q;

  for (genvar g = 0; g < STS_N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= set_i[g] | (flag_q[g] & ~clr_i[g]);
    end
  end

  assign flags_o = flag_q;

  AST_WDT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[STS_WDTO] |=> flags_o[STS_WDTO]); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[STS_IDLE] && !clr_i[STS_IDLE]) |=> flags_o[STS_IDLE]); // R11

endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl import lpm_pkg::*; #(
  parameter int NUM_SRC    = 4,
  parameter int NUM_PERIPH = 4,
  parameter int PRIO_W     = 3,
  parameter int START_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      oth_rst_i,
  input  logic                      save_req_i,
  input  logic                      save_mode_i,
  input  logic [NUM_SRC-1:0]        irq_req_i,
  input  logic [NUM_SRC-1:0]        irq_en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] irq_prio_i,
  input  logic [PRIO_W-1:0]         cpu_prio_i,
  input  logic                      wdt_to_i,
  input  logic [START_W-1:0]        start_cnt_i,
  input  logic [NUM_PERIPH-1:0]     periph_idle_run_i,
  input  logic                      cfd_en_i,
  input  logic [2:0]                sts_clr_i,
  output logic                      cpu_clk_en_o,
  output logic                      osc_en_o,
  output logic [NUM_PERIPH-1:0]     periph_clk_en_o,
  output logic                      fs_clk_en_o,
  output logic                      resume_o,
  output logic                      sts_idle_o,
  output logic                      sts_sleep_o,
  output logic                      sts_wdto_o
);

  pm_state_e state_q, state_d;

  logic [NUM_SRC-1:0] irq_cand;
  logic               irq_hit;
  logic               wake_evt;
  logic               idle_wake;
  logic               sleep_wake;
  logic               warm_done;
  logic               warm_exit;
  logic               resume_q;
  logic [STS_N-1:0]   sts_set;
  logic [STS_N-1:0]   sts_flags;

  lpm_irq_qual #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_qual (
    .req_i  (irq_req_i),
    .en_i   (irq_en_i),
    .prio_i (irq_prio_i),
    .cur_i  (cpu_prio_i),
    .cand_o (irq_cand),
    .hit_o  (irq_hit)
  );

  assign wake_evt   = irq_hit | wdt_to_i;
  assign idle_wake  = (state_q == PM_IDLE)  && wake_evt  && !oth_rst_i;
  assign sleep_wake = (state_q == PM_SLEEP) && wake_evt  && !oth_rst_i;
  assign warm_exit  = (state_q == PM_WARM)  && warm_done && !oth_rst_i;

  lpm_startup_timer #(.CNT_W(START_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (sleep_wake),
    .load_val_i (start_cnt_i),
    .run_i      (state_q == PM_WARM),
    .done_o     (warm_done)
  );

  always_comb begin
    state_d = state_q;
    if (oth_rst_i) begin
      state_d = PM_RUN;
    end else begin
      case (state_q)
        PM_RUN:   if (save_req_i) state_d = save_mode_i ? PM_SLEEP : PM_IDLE;
        PM_IDLE:  if (wake_evt)   state_d = PM_RUN;
        PM_SLEEP: if (wake_evt)   state_d = PM_WARM;
        PM_WARM:  if (warm_done)  state_d = PM_RUN;
        default:                  state_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PM_RUN;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= idle_wake | warm_exit;
    end
  end

  assign sts_set[STS_IDLE]  = idle_wake | oth_rst_i;
  assign sts_set[STS_SLEEP] = sleep_wake;
  assign sts_set[STS_WDTO]  = (idle_wake | sleep_wake) & wdt_to_i;

  lpm_status u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (sts_set),
    .clr_i   (sts_clr_i),
    .flags_o (sts_flags)
  );

  always_comb begin
    case (state_q)
      PM_RUN:  periph_clk_en_o = '1;
      PM_IDLE: periph_clk_en_o = periph_idle_run_i;
      default: periph_clk_en_o = '0;
    endcase
  end

  assign cpu_clk_en_o = (state_q == PM_RUN);
  assign osc_en_o     = (state_q != PM_SLEEP);
  assign fs_clk_en_o  = cfd_en_i && (state_q == PM_RUN || state_q == PM_IDLE);
  assign resume_o     = resume_q;
  assign sts_idle_o   = sts_flags[STS_IDLE];
  assign sts_sleep_o  = sts_flags[STS_SLEEP];
  assign sts_wdto_o   = sts_flags[STS_WDTO];

  AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> !resume_o); // R9
  AST_IDLE_WAKE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    idle_wake |=> (cpu_clk_en_o && resume_o && sts_idle_o)); // R5
  AST_WARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_WARM && !warm_done && !oth_rst_i) |=> !cpu_clk_en_o); // R7
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE && !wake_evt && !oth_rst_i) |=> (state_q == PM_IDLE)); // R12
  AST_OTHER_RST_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    oth_rst_i |=> (cpu_clk_en_o && sts_idle_o && !resume_o)); // R10

endmodule

// File: tb/lpm_wake_ctrl_test.sv
`timescale 1ns/1ps
module lpm_wake_ctrl_test;
  localparam int NS = 4, NP = 4, PW = 3, SW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, oth_rst, save_req, save_mode, wdt_to, cfd_en, resume;
  logic [NS-1:0] irq_req, irq_en;
  logic [NS*PW-1:0] irq_prio;
  logic [PW-1:0] cpu_prio;
  logic [SW-1:0] start_cnt;
  logic [NP-1:0] idle_run, periph_en;
  logic [2:0] sts_clr;
  logic cpu_en, osc_en, fs_en, f_idle, f_sleep, f_wdto;

  lpm_wake_ctrl #(.NUM_SRC(NS), .NUM_PERIPH(NP), .PRIO_W(PW), .START_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .oth_rst_i(oth_rst), .save_req_i(save_req),
    .save_mode_i(save_mode), .irq_req_i(irq_req), .irq_en_i(irq_en),
    .irq_prio_i(irq_prio), .cpu_prio_i(cpu_prio), .wdt_to_i(wdt_to),
    .start_cnt_i(start_cnt), .periph_idle_run_i(idle_run), .cfd_en_i(cfd_en),
    .sts_clr_i(sts_clr), .cpu_clk_en_o(cpu_en), .osc_en_o(osc_en),
    .periph_clk_en_o(periph_en), .fs_clk_en_o(fs_en), .resume_o(resume),
    .sts_idle_o(f_idle), .sts_sleep_o(f_sleep), .sts_wdto_o(f_wdto)
  );

  int total = 0, bad = 0;
  bit done = 0;
  // model: 0 run, 1 idle, 2 sleep, 3 start-up
  int m_st, m_wait;
  bit m_res, m_fi, m_fs, m_fw;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit irq_wakes();
    for (int i = 0; i < NS; i++) begin
      int p;
      p = int'(irq_prio[i*PW +: PW]);
      if (irq_req[i] && irq_en[i] && p > int'(cpu_prio)) return 1;
    end
    return 0;
  endfunction

  task automatic model_edge();
    bit w, si, ss, sw;
    w = irq_wakes() || wdt_to;
    si = 0; ss = 0; sw = 0; m_res = 0;
    if (oth_rst) begin
      m_st = 0; si = 1;
    end else if (m_st == 0) begin
      if (save_req) m_st = save_mode ? 2 : 1;
    end else if (m_st == 1) begin
      if (w) begin m_st = 0; m_res = 1; si = 1; sw = wdt_to; end
    end else if (m_st == 2) begin
      if (w) begin
        m_st = 3; ss = 1; sw = wdt_to;
        m_wait = (start_cnt == 0) ? 1 : int'(start_cnt);
      end
    end else begin
      m_wait--;
      if (m_wait == 0) begin m_st = 0; m_res = 1; end
    end
    m_fi = si | (m_fi & !sts_clr[0]);
    m_fs = ss | (m_fs & !sts_clr[1]);
    m_fw = sw | (m_fw & !sts_clr[2]);
  endtask

  task automatic compare();
    int pe;
    pe = (m_st == 0) ? (1 << NP) - 1 : (m_st == 1) ? int'(idle_run) : 0;
    chk("R5/R7 cpu_clk_en", int'(cpu_en), int'(m_st == 0));
    chk("R6/R7 osc_en", int'(osc_en), int'(m_st != 2));
    chk("R2/R6 periph_clk_en", int'(periph_en), pe);
    chk("R3 fs_clk_en", int'(fs_en), int'(cfd_en && m_st <= 1));
    chk("R9 resume", int'(resume), int'(m_res));
    chk("R11 idle flag", int'(f_idle), int'(m_fi));
    chk("R11 sleep flag", int'(f_sleep), int'(m_fs));
    chk("R8 wdto flag", int'(f_wdto), int'(m_fw));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    oth_rst = 0; save_req = 0; wdt_to = 0; irq_req = '0; sts_clr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    rst_n = 0; quiet(); save_mode = 0; irq_en = '0; irq_prio = '0;
    cpu_prio = '0; start_cnt = 8'd16; idle_run = 4'b0101; cfd_en = 1;
    m_st = 0; m_wait = 0; m_res = 0; m_fi = 0; m_fs = 0; m_fw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    compare();
    chk("R1 cpu_clk_en after reset", int'(cpu_en), 1);
    cyc();

    // R2 enter Idle
    cpu_prio = 3'd3; save_req = 1; save_mode = 0; cyc(); quiet();
    chk("R2 idle periph mask", int'(periph_en), 5);
    // R4 equal priority does not wake
    irq_en = 4'b0001; irq_prio = 12'h003; irq_req = 4'b0001; cyc(); quiet();
    chk("R4 equal prio stays", int'(cpu_en), 0);
    // R4 disabled source with high priority does not wake
    irq_prio = 12'h070; irq_req = 4'b0010; cyc(); quiet();
    chk("R4 disabled stays", int'(cpu_en), 0);
    // R5 higher priority wakes
    irq_prio = 12'h004; irq_req = 4'b0001; cyc(); quiet();
    chk("R5 resume on idle wake", int'(resume), 1);
    chk("R5 idle flag", int'(f_idle), 1);
    cyc();
    chk("R9 resume single", int'(resume), 0);
    // R11 clear idle flag
    sts_clr = 3'b001; cyc(); quiet();
    chk("R11 idle cleared", int'(f_idle), 0);

    // R6 Sleep, R12 ignored request, R7 start-up delay, R8 wdt in sleep
    save_req = 1; save_mode = 1; cyc(); quiet();
    chk("R6 osc off", int'(osc_en), 0);
    save_req = 1; save_mode = 0; cyc(); quiet();
    chk("R12 request ignored", int'(osc_en), 0);
    start_cnt = 8'd16; wdt_to = 1; cyc(); quiet();
    chk("R8 sleep flag", int'(f_sleep), 1);
    chk("R8 wdto flag", int'(f_wdto), 1);
    n = 0;
    while (!cpu_en && n < 100) begin cyc(); n++; end
    chk("R7 start-up cycles", n, 16);
    chk("R7 resume with clock", int'(resume), 1);
    cyc();

    // R8 wdt while running
    sts_clr = 3'b111; cyc(); quiet();
    wdt_to = 1; cyc(); quiet();
    chk("R8 wdt in run no flag", int'(f_wdto), 0);

    // R10 other reset in Idle overrides request
    save_req = 1; save_mode = 0; cyc(); quiet();
    oth_rst = 1; save_req = 1; save_mode = 1; cyc(); quiet();
    chk("R10 running", int'(cpu_en), 1);
    chk("R10 idle flag", int'(f_idle), 1);
    chk("R10 no resume", int'(resume), 0);
    cyc();
    chk("R10 request dropped", int'(osc_en), 1);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      save_req  = ($urandom % 6) == 0;
      save_mode = $urandom % 2;
      irq_req   = NS'($urandom & $urandom & $urandom);
      irq_en    = NS'($urandom);
      irq_prio  = (NS*PW)'($urandom);
      cpu_prio  = PW'($urandom);
      wdt_to    = ($urandom % 40) == 0;
      oth_rst   = ($urandom % 200) == 0;
      sts_clr   = (($urandom % 16) == 0) ? 3'($urandom) : 3'b000;
      start_cnt = SW'($urandom % 20);
      idle_run  = NP'($urandom);
      cfd_en    = $urandom % 2;
      cyc();
    end
    quiet();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule